// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This engine erases a byte range of a paged serial flash by driving a byte-level SPI master. The caller gives a start byte offset and a byte length and pulses `start_i`. Both values must be whole multiples of the page size `PAGE_BYTES`. If either is not, the range is rejected at once with no bus traffic. A length of zero completes with no bus traffic at all.

For an accepted range the engine walks it one page at a time. At each step it issues one erase command of four bytes: an opcode, two address bytes and a filler byte. The device address is the page index shifted left by `PAGE_SHIFT`, so pages whose size is not a power of two are handled. Block erase (eight pages) is chosen when the current page index is a multiple of eight and at least eight pages remain. Page erase is chosen otherwise. Whatever erase was issued, the step moves forward by exactly one page.

After each command the engine polls the device status in separate transactions until the ready bit is set. If `TIMEOUT_CYC` clock cycles pass after the command without a ready status, the engine stops with a timeout error.

The controller passes through these states:

| State | Role |
|---|---|
| S_IDLE | Waits for `start_i`. |
| S_CMD | Shifts out the four command bytes. |
| S_GAP | Chip select is low for one cycle. |
| S_POLL_OP | Sends the status opcode. |
| S_POLL_RD | Sends a dummy byte and captures the status. |
| S_EVAL | Decides the next move. |
| S_DONE | One-cycle completion. |

The transitions are:
- start → S_CMD or S_DONE
- last byte → S_GAP
- S_GAP → S_POLL_OP
- byte accepted → S_POLL_RD
- byte accepted → S_EVAL
- ready → S_CMD or S_DONE
- not ready → S_GAP, or S_DONE on timeout
- S_DONE → S_IDLE

Top module: `flash_erase_engine`

## Requirements
- R1: If the offset or the length is not a whole multiple of PAGE_BYTES, the engine sets `err_align_o`, pulses `done_o` and never asserts `spi_cs_o` for that request.
- R2: An aligned request of length zero pulses `done_o` with both error flags low and makes no SPI transaction.
- R3: The opcode is 0x50 (block erase) when the current page index has its low three bits equal to zero and at least 8 pages remain. In every other case it is 0x81 (page erase).
- R4: Each erase command is one chip-select transaction of exactly four bytes, in this order: the opcode, address bits 23:16, address bits 15:8, then 0x00. The address is the page index shifted left by PAGE_SHIFT.
- R5: After each erase command, the status is read in separate two-byte transactions. The first byte is 0xD7 and the second is 0x00. Chip select is low between any two transactions.
- R6: Only bit 7 of the byte received during the second status byte decides readiness, where 1 means ready. Polling repeats until that bit is 1.
- R7: Each completed step advances the page index by one and reduces the remaining count by one page, whether the step was a block erase or a page erase. When no pages remain, `done_o` pulses and `busy_o` is low.
- R8: If `TIMEOUT_CYC` cycles pass after a command without a ready status, the engine sets `err_timeout_o`, pulses `done_o`, and issues no further transaction.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: `busy_o` is high from the accepted start until completion. `done_o` is a single-cycle pulse with `busy_o` low. Both error flags are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled in idle |
| offset_i | input | ADDR_W | Start byte offset |
| length_i | input | ADDR_W | Byte length to erase |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_align_o | output | 1 | Last request was misaligned |
| err_timeout_o | output | 1 | Last request timed out while polling |
| spi_cs_o | output | 1 | Chip select, high while a transaction is open |
| spi_req_o | output | 1 | Byte to exchange is presented |
| spi_tx_o | output | 8 | Byte to send |
| spi_ack_i | input | 1 | Shifter has exchanged the presented byte |
| spi_rx_i | input | 8 | Byte received in the exchange being acknowledged |

## Verification
Ranges are chosen to separate the two opcodes:
- A sixteen-page range from page 0 shows that block erase is picked only at pages 0 and 8, and that each block erase still advances by a single page.
- A range starting at page 3 never meets the block condition.
- A range at page 200 exercises the upper address byte.

Status handling is covered in three ways:
- A device that answers not-ready three times per step, with every bit except bit 7 set, shows that only the ready bit counts.
- A device that never becomes ready tells a timeout apart from an endless poll.
- A second start in the middle of a run, with misaligned values, must leave the command stream and the flags unchanged.

// File: rtl/fee_pkg.sv
package fee_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_POLL_OP,
        S_POLL_RD,
        S_EVAL,
        S_DONE
    } fee_state_e;

    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OPC_STATUS      = 8'hD7;
    localparam logic [7:0] BYTE_FILL       = 8'h00;
    localparam int         BLOCK_PAGES     = 8;
    localparam int         CMD_BYTES       = 4;
    localparam int         READY_BIT       = 7;
endpackage

// File: rtl/fee_range_calc.sv
module fee_range_calc #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 264
) (
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic              aligned_o,
    output logic [ADDR_W-1:0] first_page_o,
    output logic [ADDR_W-1:0] page_cnt_o
);
    localparam logic [ADDR_W-1:0] PB = ADDR_W'(PAGE_BYTES);

    always_comb begin
        aligned_o    = ((offset_i % PB) == '0) && ((len_i % PB) == '0);
        first_page_o = offset_i / PB;
        page_cnt_o   = len_i / PB;
    end
endmodule

// File: rtl/fee_cmd_builder.sv
module fee_cmd_builder
    import fee_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 9
) (
    input  logic [ADDR_W-1:0] page_idx_i,
    input  logic [ADDR_W-1:0] pages_left_i,
    input  logic [1:0]        byte_sel_i,
    output logic [7:0]        byte_o
);
    localparam int BLK_BITS = $clog2(BLOCK_PAGES);

    logic [23:0] dev_addr;
    logic        use_block;

    always_comb begin
        dev_addr  = 24'(page_idx_i) << PAGE_SHIFT;
        use_block = (page_idx_i[BLK_BITS-1:0] == '0) &&
                    (pages_left_i >= ADDR_W'(BLOCK_PAGES));
        unique case (byte_sel_i)
            2'd0: byte_o = use_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;
            2'd1: byte_o = dev_addr[23:16];
            2'd2: byte_o = dev_addr[15:8];
            2'd3: byte_o = BYTE_FILL;
        endcase
    end
endmodule

// File: rtl/fee_poll_timer.sv
module fee_poll_timer #(
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= TW'(TIMEOUT_CYC));
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
    import fee_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_BYTES  = 264,
    parameter int PAGE_SHIFT  = 9,
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] length_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_align_o,
    output logic              err_timeout_o,
    output logic              spi_cs_o,
    output logic              spi_req_o,
    output logic [7:0]        spi_tx_o,
    input  logic              spi_ack_i,
    input  logic [7:0]        spi_rx_i
);
    localparam logic [1:0] LAST_BYTE = 2'(CMD_BYTES - 1);

    fee_state_e        state_q, state_d;
    logic [ADDR_W-1:0] page_idx_q, pages_left_q;
    logic [1:0]        byte_sel_q;
    logic              ready_q, err_align_q, err_tmo_q;

    logic              aligned;
    logic [ADDR_W-1:0] first_page, page_cnt;
    logic [7:0]        cmd_byte;
    logic              tmo_expired;

    fee_range_calc #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .offset_i     (offset_i),
        .len_i        (length_i),
        .aligned_o    (aligned),
        .first_page_o (first_page),
        .page_cnt_o   (page_cnt)
    );

    fee_cmd_builder #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_cmd (
        .page_idx_i   (page_idx_q),
        .pages_left_i (pages_left_q),
        .byte_sel_i   (byte_sel_q),
        .byte_o       (cmd_byte)
    );

    fee_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_q == S_CMD),
        .run_i     (state_q inside {S_GAP, S_POLL_OP, S_POLL_RD, S_EVAL}),
        .expired_o (tmo_expired)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (!aligned || page_cnt == '0) state_d = S_DONE;
                    else                            state_d = S_CMD;
                end
            end
            S_CMD:     if (spi_ack_i && byte_sel_q == LAST_BYTE) state_d = S_GAP;
            S_GAP:     state_d = S_POLL_OP;
            S_POLL_OP: if (spi_ack_i) state_d = S_POLL_RD;
            S_POLL_RD: if (spi_ack_i) state_d = S_EVAL;
            S_EVAL: begin
                if (ready_q)          state_d = (pages_left_q == ADDR_W'(1)) ? S_DONE : S_CMD;
                else if (tmo_expired) state_d = S_DONE;
                else                  state_d = S_GAP;
            end
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // walk registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_idx_q   <= '0;
            pages_left_q <= '0;
            byte_sel_q   <= '0;
            ready_q      <= 1'b0;
            err_align_q  <= 1'b0;
            err_tmo_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        err_align_q  <= !aligned;
                        err_tmo_q    <= 1'b0;
                        page_idx_q   <= first_page;
                        pages_left_q <= page_cnt;
                        byte_sel_q   <= '0;
                    end
                end
                S_CMD:     if (spi_ack_i) byte_sel_q <= byte_sel_q + 1'b1;
                S_POLL_RD: if (spi_ack_i) ready_q <= spi_rx_i[READY_BIT];
                S_EVAL: begin
                    if (ready_q) begin
                        page_idx_q   <= page_idx_q + 1'b1;
                        pages_left_q <= pages_left_q - 1'b1;
                    end else if (tmo_expired) begin
                        err_tmo_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_cs_o      = 1'b0;
        spi_req_o     = 1'b0;
        spi_tx_o      = BYTE_FILL;
        busy_o        = !(state_q inside {S_IDLE, S_DONE});
        done_o        = (state_q == S_DONE);
        err_align_o   = err_align_q;
        err_timeout_o = err_tmo_q;
        unique case (state_q)
            S_CMD:     begin spi_cs_o = 1'b1; spi_req_o = 1'b1; spi_tx_o = cmd_byte;   end
            S_POLL_OP: begin spi_cs_o = 1'b1; spi_req_o = 1'b1; spi_tx_o = OPC_STATUS; end
            S_POLL_RD: begin spi_cs_o = 1'b1; spi_req_o = 1'b1; spi_tx_o = BYTE_FILL;  end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_erase_engine_chk.sv
module flash_erase_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_align_o,
    input logic       err_timeout_o,
    input logic       spi_cs_o,
    input logic       spi_req_o,
    input logic [7:0] spi_tx_o,
    input logic       spi_ack_i,
    input logic [7:0] spi_rx_i
);
    assert_req_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |-> spi_cs_o);

    assert_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o)));

    assert_rx_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ack_i |-> !$isunknown(spi_rx_i));

    assert_misalign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_align_o |-> !spi_cs_o);

    assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout_o |-> !spi_cs_o);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_fresh_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!err_align_o && !err_timeout_o));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !spi_cs_o);
endmodule

bind flash_erase_engine flash_erase_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_align_o   (err_align_o),
    .err_timeout_o (err_timeout_o),
    .spi_cs_o      (spi_cs_o),
    .spi_req_o     (spi_req_o),
    .spi_tx_o      (spi_tx_o),
    .spi_ack_i     (spi_ack_i),
    .spi_rx_i      (spi_rx_i)
);

// File: tb/flash_erase_engine_test.sv
module flash_erase_engine_test;
    localparam int ADDR_W = 24;
    localparam int PB     = 264;
    localparam int SHIFT  = 9;
    localparam int TMO    = 300;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] offset = '0, length = '0;
    logic busy, done, err_align, err_tmo, cs, req, ack = 1'b0;
    logic [7:0] tx, rx = 8'h00;

    int checks = 0, fails = 0;
    int busy_polls = 0, polls_since_cmd = 0, total_polls = 0, total_cmds = 0, total_txn = 0;
    int lat_cnt = 0, cur_len = 0;
    logic [7:0] cur [0:7];
    logic [31:0] expq [$];

    always #10 clk = ~clk;

    flash_erase_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .PAGE_SHIFT(SHIFT),
                         .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .offset_i(offset), .length_i(length),
        .busy_o(busy), .done_o(done), .err_align_o(err_align), .err_timeout_o(err_tmo),
        .spi_cs_o(cs), .spi_req_o(req), .spi_tx_o(tx), .spi_ack_i(ack), .spi_rx_i(rx));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // byte shifter model and transaction monitor (scoreboard consumer)
    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (req) begin
            lat_cnt++;
            if (lat_cnt == LAT) begin
                lat_cnt = 0;
                if (cur_len == 1 && cur[0] == 8'hD7)
                    rx = (polls_since_cmd >= busy_polls) ? 8'h80 : 8'h7F;
                else
                    rx = 8'h00;
                if (cur_len < 8) cur[cur_len] = tx;
                cur_len++;
                ack = 1'b1;
            end
        end
        if (!cs && cur_len > 0) begin
            total_txn++;
            if (cur_len == 2 && cur[0] == 8'hD7) begin
                check(cur[1] == 8'h00, "R5 status dummy byte", cur[1], 0);
                polls_since_cmd++;
                total_polls++;
            end else if (cur_len == 4) begin
                total_cmds++;
                polls_since_cmd = 0;
                if (expq.size() == 0) begin
                    check(0, "R4 unexpected command", {cur[0], cur[1], cur[2], cur[3]}, 0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check({cur[0], cur[1], cur[2], cur[3]} == e, "R3/R4 command bytes",
                          {cur[0], cur[1], cur[2], cur[3]}, e);
                end
            end else begin
                check(0, "R5 malformed transaction length", cur_len, 0);
            end
            cur_len = 0;
        end
    end

    // driver: compute expected commands from the requirements and push them
    task automatic push_expected(input int first_pg, input int npg, input int max_steps);
        int pg = first_pg, n = npg, steps = 0;
        while (n > 0 && steps < max_steps) begin
            logic [7:0] op;
            logic [23:0] a;
            op = ((pg % 8) == 0 && n >= 8) ? 8'h50 : 8'h81;
            a  = 24'(pg << SHIFT);
            expq.push_back({op, a[23:16], a[15:8], 8'h00});
            pg++; n--; steps++;
        end
    endtask

    task automatic run_erase(input int off, input int len, input int max_steps,
                             input bit exp_align, input bit exp_tmo,
                             input bit poke, input string tag);
        int cmd0 = total_cmds, txn0 = total_txn, nsteps = 0;
        bit seen = 0;
        if (!exp_align && len / PB > 0) begin
            push_expected(off / PB, len / PB, max_steps);
            nsteps = (len / PB < max_steps) ? len / PB : max_steps;
        end
        @(negedge clk);
        offset = ADDR_W'(off); length = ADDR_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (25) @(negedge clk);
            check(busy == 1'b1, "R9 busy before poke", busy, 1);
            offset = ADDR_W'(7); length = ADDR_W'(5); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 20000; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, {tag, " done pulse"}, seen, 1);
        check(busy == 1'b0, {tag, " R10 not busy at done"}, busy, 0);
        check(err_align == exp_align, {tag, " R1 align flag"}, err_align, exp_align);
        check(err_tmo == exp_tmo, {tag, " R8 timeout flag"}, err_tmo, exp_tmo);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 done is one cycle"}, done, 0);
        check(expq.size() == 0, {tag, " R7 all expected commands seen"}, expq.size(), 0);
        check(total_cmds - cmd0 == nsteps, {tag, " R7 command count"}, total_cmds - cmd0, nsteps);
        if (exp_align || nsteps == 0)
            check(total_txn == txn0, {tag, " R1/R2 no bus traffic"}, total_txn - txn0, 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && cs == 0 && req == 0, "R10 reset outputs",
              {busy, done, cs, req}, 0);
        check(err_align == 0 && err_tmo == 0, "R10 reset flags", {err_align, err_tmo}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: misaligned offset, then misaligned length
        run_erase(100, PB, 1000, 1, 0, 0, "R1 offset");
        run_erase(PB, 300, 1000, 1, 0, 0, "R1 length");

        // R2: zero length
        run_erase(2 * PB, 0, 1000, 0, 0, 0, "R2 zero");

        // R3 R4 R7: sixteen pages from page 0, device ready at once
        busy_polls = 0;
        p0 = total_polls;
        run_erase(0, 16 * PB, 1000, 0, 0, 0, "R3 aligned walk");
        check(total_polls - p0 == 16, "R5 one poll per step", total_polls - p0, 16);

        // R6: start at page 3, three not-ready answers (0x7F) per step
        busy_polls = 3;
        p0 = total_polls;
        run_erase(3 * PB, 10 * PB, 1000, 0, 0, 0, "R6 unaligned walk");
        check(total_polls - p0 == 40, "R6 polls until bit7", total_polls - p0, 40);

        // R4: high address byte, block at page 200
        busy_polls = 0;
        run_erase(200 * PB, 9 * PB, 1000, 0, 0, 0, "R4 high page");

        // R9: start during a run is ignored
        busy_polls = 1;
        run_erase(8 * PB, 8 * PB, 1000, 0, 0, 1, "R9 ignored start");

        // R8: device never ready
        busy_polls = 1000000;
        p0 = total_txn;
        run_erase(0, 2 * PB, 1, 0, 1, 0, "R8 timeout");
        check(total_polls > 0, "R8 polled before giving up", total_polls, 1);
        p0 = total_txn;
        repeat (100) @(negedge clk);
        check(total_txn == p0 && cs == 0, "R8 silent after timeout", total_txn - p0, 0);

        // R10: next start clears timeout flag
        busy_polls = 0;
        run_erase(5 * PB, PB, 1000, 0, 0, 0, "R10 recovery");

        report();
        $finish;
    end
endmodule